// File: doc/BRIEF.md
# Flash Command State Machine

This block is the device-side command interpreter of a byte-wide flash array. It watches write cycles on an active-low chip-enable / write-enable / output-enable bus. Every change to the array needs two writes: a setup byte that names the operation, then an execute write that confirms it. Three operations exist: byte program, sector erase and whole-array erase. Writing 0xFF after a setup cancels it. The same byte stops an erase that is already running.

Each accepted operation runs under an internal timer and raises `busy` until the timer expires. After reset the block is in read mode and write-protected. An `unlock` pulse clears the protection. The array is a small register memory that powers up erased (every byte 0xFF). Timer lengths are parameters, kept short for simulation.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A read cycle is `ce_n`=0, `oe_n`=0 and `we_n`=1. During a read cycle `dout_en` is 1 and `dout` shows the array byte at `addr`. Outside a read cycle `dout_en` is 0. After reset every byte reads 0xFF.
- R2: Reset makes the block write-protected. While it is protected, every write is ignored and the array does not change. A one-cycle `unlock` pulse removes the protection. Only a reset restores it.
- R3: Setup byte 0x10 followed by any other write programs that second write's address. The new byte is the old byte AND the written data, so programming can only clear bits.
- R4: Setup byte 0x20 followed by execute byte 0xD0 erases one 256-byte sector to 0xFF. The sector is the one selected by the execute address bits above bit 7. All other sectors keep their contents.
- R5: Setup byte 0x30 followed by a second 0x30 erases every byte of the array to 0xFF.
- R6: A write of 0xFF right after any setup byte cancels the operation. The array is left unchanged, the block returns to read mode and the protection stays cleared.
- R7: An execute byte that neither matches the setup nor equals 0xFF throws the sequence away and leaves the array unchanged. In read mode, a byte that is not a setup byte is ignored.
- R8: `busy` goes high two clock edges after the execute write strobe ends. It stays high for at least the operation's timer length, in cycles. It stays high until any erase sweep has finished.
- R9: A write of 0xFF while an erase is running stops it at once. The bytes already swept read 0xFF and the rest keep their old values. Issuing the same erase again completes it.
- R10: A write strobe is the time when both `ce_n` and `we_n` are low. The address is taken when the strobe starts. The data is the last value seen while the strobe is still active.
- R11: While an operation runs, every write except 0xFF is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets protection and erases the array |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| unlock | input | 1 | One-cycle pulse that clears write protection |
| dout | output | 8 | Read data, 0 outside a read cycle |
| dout_en | output | 1 | High during a read cycle |
| busy | output | 1 | An operation is running |

## Verification
The hardest state to reach is a sector erase that has been stopped partway. The bench has to land an abort write inside a sweep that moves one byte per cycle. It then has to prove, from the read port alone, that some bytes are cleared and others are not.

To do this, the bench first programs a byte at the start of a sector and another byte near its end. It starts the sector erase and waits a few cycles. It then sends an ignored program setup byte, followed by the 0xFF abort. At that point only the low end of the sector has been swept. Finally it reissues the erase and checks that the remaining byte reads 0xFF.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_SE_SETUP,
        ST_CE_SETUP,
        ST_PG_SETUP,
        ST_RUN
    } cmd_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT_ERASE,
        OP_CHIP_ERASE
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [7:0]  data;
    } op_req_t;

    localparam logic [7:0] CODE_PROG_SETUP = 8'h10;
    localparam logic [7:0] CODE_SECT_SETUP = 8'h20;
    localparam logic [7:0] CODE_SECT_GO    = 8'hD0;
    localparam logic [7:0] CODE_CHIP_SETUP = 8'h30;
    localparam logic [7:0] CODE_CHIP_GO    = 8'h30;
    localparam logic [7:0] CODE_CANCEL     = 8'hFF;
    localparam logic [7:0] BYTE_BLANK      = 8'hFF;

    // Programming can only pull bits low.
    function automatic logic [7:0] merge_prog(input logic [7:0] old_b, input logic [7:0] new_b);
        return old_b & new_b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [7:0]        evt_data
);
    logic              strobe;
    logic              strobe_q;
    logic [ADDR_W-1:0] addr_lat;
    logic [7:0]        data_lat;

    assign strobe = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            addr_lat <= '0;
            data_lat <= '0;
            wr_evt   <= 1'b0;
            evt_addr <= '0;
            evt_data <= '0;
        end else begin
            strobe_q <= strobe;
            wr_evt   <= 1'b0;
            // address at strobe start
            if (strobe && !strobe_q) begin
                addr_lat <= addr;
            end
            // data follows the bus while the strobe is active
            if (strobe) begin
                data_lat <= din;
            end
            // strobe end: hand the completed write on
            if (!strobe && strobe_q) begin
                wr_evt   <= 1'b1;
                evt_addr <= addr_lat;
                evt_data <= data_lat;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [7:0]        evt_data,
    input  logic              unlock,
    input  logic              busy,
    output logic              start,
    output op_req_t           start_req,
    output logic [ADDR_W-1:0] start_addr,
    output logic              abort,
    output logic              prot_on
);
    cmd_state_e state_q, state_d;

    always_comb begin
        state_d        = state_q;
        start          = 1'b0;
        abort          = 1'b0;
        start_req.kind = OP_NONE;
        start_req.data = evt_data;
        start_addr     = evt_addr;
        unique case (state_q)
            ST_READ: begin
                if (wr_evt && !prot_on) begin
                    if (evt_data == CODE_PROG_SETUP)      state_d = ST_PG_SETUP;
                    else if (evt_data == CODE_SECT_SETUP) state_d = ST_SE_SETUP;
                    else if (evt_data == CODE_CHIP_SETUP) state_d = ST_CE_SETUP;
                end
            end
            ST_PG_SETUP: begin
                if (wr_evt) begin
                    if (evt_data == CODE_CANCEL) begin
                        state_d = ST_READ;
                    end else begin
                        start          = 1'b1;
                        start_req.kind = OP_PROG;
                        state_d        = ST_RUN;
                    end
                end
            end
            ST_SE_SETUP: begin
                if (wr_evt) begin
                    if (evt_data == CODE_SECT_GO) begin
                        start          = 1'b1;
                        start_req.kind = OP_SECT_ERASE;
                        state_d        = ST_RUN;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_CE_SETUP: begin
                if (wr_evt) begin
                    if (evt_data == CODE_CHIP_GO) begin
                        start          = 1'b1;
                        start_req.kind = OP_CHIP_ERASE;
                        state_d        = ST_RUN;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_RUN: begin
                if (wr_evt && evt_data == CODE_CANCEL) begin
                    abort   = 1'b1;
                    state_d = ST_READ;
                end else if (!busy) begin
                    state_d = ST_READ;
                end
            end
            default: state_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READ;
            prot_on <= 1'b1;
        end else begin
            state_q <= state_d;
            if (unlock) begin
                prot_on <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int SECT_W   = 8,
    parameter int T_PROG   = 16,
    parameter int T_SERASE = 300,
    parameter int T_CERASE = 1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_req_t           req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              abort,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_erase,
    output logic [7:0]        arr_data
);
    localparam int T_MAX      = max3(T_PROG, T_SERASE, T_CERASE);
    localparam int CNT_W      = $clog2(T_MAX + 1);
    localparam int LEFT_W     = ADDR_W + 1;
    localparam int SECT_BYTES = 1 << SECT_W;
    localparam int ARR_BYTES  = 1 << ADDR_W;

    logic [CNT_W-1:0]  tmr;
    logic [ADDR_W-1:0] sweep_ptr;
    logic [LEFT_W-1:0] sweep_left;
    logic              prog_pend;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;

    assign arr_we    = busy && (prog_pend || sweep_left != '0);
    assign arr_addr  = prog_pend ? prog_addr : sweep_ptr;
    assign arr_erase = !prog_pend;
    assign arr_data  = prog_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            tmr        <= '0;
            sweep_ptr  <= '0;
            sweep_left <= '0;
            prog_pend  <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
        end else if (abort) begin
            busy       <= 1'b0;
            tmr        <= '0;
            sweep_left <= '0;
            prog_pend  <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            unique case (req.kind)
                OP_PROG: begin
                    tmr       <= CNT_W'(T_PROG - 1);
                    prog_pend <= 1'b1;
                    prog_addr <= req_addr;
                    prog_data <= req.data;
                end
                OP_SECT_ERASE: begin
                    tmr        <= CNT_W'(T_SERASE - 1);
                    sweep_ptr  <= {req_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
                    sweep_left <= LEFT_W'(SECT_BYTES);
                end
                OP_CHIP_ERASE: begin
                    tmr        <= CNT_W'(T_CERASE - 1);
                    sweep_ptr  <= '0;
                    sweep_left <= LEFT_W'(ARR_BYTES);
                end
                default: busy <= 1'b0;
            endcase
        end else if (busy) begin
            prog_pend <= 1'b0;
            if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
            if (sweep_left != '0) begin
                sweep_ptr  <= sweep_ptr + 1'b1;
                sweep_left <= sweep_left - 1'b1;
            end
            if (tmr == '0 && sweep_left == '0 && !prog_pend) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              erase,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= BYTE_BLANK;
            end
        end else if (we) begin
            mem[waddr] <= erase ? BYTE_BLANK : merge_prog(mem[waddr], wdata);
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int SECT_W   = 8,
    parameter int T_PROG   = 16,
    parameter int T_SERASE = 300,
    parameter int T_CERASE = 1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              unlock,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    logic              wr_evt;
    logic [ADDR_W-1:0] evt_addr;
    logic [7:0]        evt_data;
    logic              cmd_start;
    logic              cmd_abort;
    op_req_t           cmd_req;
    logic [ADDR_W-1:0] cmd_addr;
    logic              prot_on;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic              arr_erase;
    logic [7:0]        arr_data;
    logic [7:0]        rd_byte;

    flash_bus_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .wr_evt   (wr_evt),
        .evt_addr (evt_addr),
        .evt_data (evt_data)
    );

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_decoder (
        .clk        (clk),
        .rst        (rst),
        .wr_evt     (wr_evt),
        .evt_addr   (evt_addr),
        .evt_data   (evt_data),
        .unlock     (unlock),
        .busy       (busy),
        .start      (cmd_start),
        .start_req  (cmd_req),
        .start_addr (cmd_addr),
        .abort      (cmd_abort),
        .prot_on    (prot_on)
    );

    flash_op_engine #(
        .ADDR_W   (ADDR_W),
        .SECT_W   (SECT_W),
        .T_PROG   (T_PROG),
        .T_SERASE (T_SERASE),
        .T_CERASE (T_CERASE)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .req       (cmd_req),
        .req_addr  (cmd_addr),
        .abort     (cmd_abort),
        .busy      (busy),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_erase (arr_erase),
        .arr_data  (arr_data)
    );

    flash_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr (arr_addr),
        .erase (arr_erase),
        .wdata (arr_data),
        .raddr (addr),
        .rdata (rd_byte)
    );

    assign dout_en = !ce_n && !oe_n && we_n;
    assign dout    = dout_en ? rd_byte : 8'h00;
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int T_PROG   = 16,
    parameter int T_SERASE = 300,
    parameter int T_CERASE = 1100
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cmd_start,
    input logic cmd_abort,
    input logic prot_on,
    input logic arr_we
);
    localparam int T_MIN_AB = (T_PROG < T_SERASE) ? T_PROG : T_SERASE;
    localparam int T_MIN    = (T_MIN_AB < T_CERASE) ? T_MIN_AB : T_CERASE;

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (cmd_start) begin
            run_cnt <= 1;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    a_r2_locked_no_write: assert property (@(posedge clk) disable iff (rst)
        prot_on |-> !arr_we);

    a_r3_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> !busy);

    a_r6_abort_clears_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_abort |=> !busy);

    a_r6_start_abort_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_start, cmd_abort}));

    a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> busy);

    a_r8_busy_min_time: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cmd_abort)) |-> (run_cnt >= T_MIN));

    a_r11_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !arr_we);
endmodule

bind flash_cmd_fsm flash_cmd_checker #(
    .T_PROG   (T_PROG),
    .T_SERASE (T_SERASE),
    .T_CERASE (T_CERASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .cmd_start (cmd_start),
    .cmd_abort (cmd_abort),
    .prot_on   (prot_on),
    .arr_we    (arr_we)
);

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          unlock = 1'b0;
    logic [7:0]    dout;
    logic          dout_en;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_fsm u_flash_cmd_fsm (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .unlock  (unlock),
        .dout    (dout),
        .dout_en (dout_en),
        .busy    (busy)
    );

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_WT = 2'd2;
    localparam logic [1:0] K_UL = 2'd3;

    typedef struct packed {
        logic [1:0]    kind;
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t VEC [NV] = '{
        '{K_RD, 10'h005, 8'hFF, 4'd1},   // R1 erased after reset
        '{K_WR, 10'h005, 8'h10, 4'd2},   // R2 protected: ignored
        '{K_WR, 10'h005, 8'h00, 4'd2},
        '{K_WT, 10'h000, 8'h00, 4'd2},
        '{K_RD, 10'h005, 8'hFF, 4'd2},
        '{K_UL, 10'h000, 8'h00, 4'd2},
        '{K_WR, 10'h005, 8'h10, 4'd3},   // R3 program
        '{K_WR, 10'h005, 8'h3C, 4'd3},
        '{K_WT, 10'h000, 8'h00, 4'd3},
        '{K_RD, 10'h005, 8'h3C, 4'd3},
        '{K_WR, 10'h005, 8'h10, 4'd3},   // R3 AND merge
        '{K_WR, 10'h005, 8'hF5, 4'd3},
        '{K_WT, 10'h000, 8'h00, 4'd3},
        '{K_RD, 10'h005, 8'h34, 4'd3},
        '{K_WR, 10'h107, 8'h10, 4'd6},   // R6 cancel program
        '{K_WR, 10'h107, 8'hFF, 4'd6},
        '{K_WR, 10'h107, 8'h00, 4'd7},   // R7 plain byte in read mode
        '{K_WT, 10'h000, 8'h00, 4'd6},
        '{K_RD, 10'h107, 8'hFF, 4'd6},
        '{K_WR, 10'h107, 8'h10, 4'd6},   // R6 still unlocked
        '{K_WR, 10'h107, 8'hA5, 4'd6},
        '{K_WT, 10'h000, 8'h00, 4'd6},
        '{K_RD, 10'h107, 8'hA5, 4'd6},
        '{K_WR, 10'h2FF, 8'h10, 4'd3},
        '{K_WR, 10'h2FF, 8'h22, 4'd3},
        '{K_WT, 10'h000, 8'h00, 4'd3},
        '{K_RD, 10'h2FF, 8'h22, 4'd3},
        '{K_WR, 10'h005, 8'h20, 4'd7},   // R7 wrong execute
        '{K_WR, 10'h005, 8'h33, 4'd7},
        '{K_WR, 10'h005, 8'hD0, 4'd7},
        '{K_WT, 10'h000, 8'h00, 4'd7},
        '{K_RD, 10'h005, 8'h34, 4'd7},
        '{K_WR, 10'h1A0, 8'h20, 4'd4},   // R4 erase sector 1
        '{K_WR, 10'h1A0, 8'hD0, 4'd4},
        '{K_WT, 10'h000, 8'h00, 4'd4},
        '{K_RD, 10'h107, 8'hFF, 4'd4},
        '{K_RD, 10'h005, 8'h34, 4'd4},
        '{K_RD, 10'h2FF, 8'h22, 4'd4},
        '{K_WR, 10'h000, 8'h30, 4'd7},   // R7 wrong chip execute
        '{K_WR, 10'h000, 8'hD0, 4'd7},
        '{K_WT, 10'h000, 8'h00, 4'd7},
        '{K_RD, 10'h2FF, 8'h22, 4'd7},
        '{K_WR, 10'h000, 8'h30, 4'd5},   // R5 chip erase
        '{K_WR, 10'h000, 8'h30, 4'd5},
        '{K_WT, 10'h000, 8'h00, 4'd5},
        '{K_RD, 10'h005, 8'hFF, 4'd5},
        '{K_RD, 10'h2FF, 8'hFF, 4'd5},
        '{K_RD, 10'h107, 8'hFF, 4'd5}
    };

    task automatic check(input bit ok, input int req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        din  = d;
        ce_n = 1'b0;
        we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr = a;
        ce_n = 1'b0;
        oe_n = 1'b0;
        #1;
        check(dout_en === 1'b1 && dout === exp, req, int'(dout), int'(exp), $sformatf("read @%0h", a));
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    task automatic wait_idle(input int req);
        int n;
        n = 0;
        repeat (2) @(negedge clk);
        while (busy === 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) check(1'b0, req, 1, 0, "busy never cleared");
    endtask

    task automatic pulse_unlock();
        @(negedge clk);
        unlock = 1'b1;
        @(negedge clk);
        unlock = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int bcnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 idle after reset, R1 no drive while bus idle
        check(busy === 1'b0, 8, int'(busy), 0, "busy after reset");
        check(dout_en === 1'b0, 1, int'(dout_en), 0, "dout_en idle");

        // R1: oe low but we low is not a read (write while protected is ignored)
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; din = 8'h10;
        #1;
        check(dout_en === 1'b0, 1, int'(dout_en), 0, "dout_en with we low");
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].kind)
                K_WR: bus_write(VEC[i].a, VEC[i].d);
                K_RD: bus_read(VEC[i].a, VEC[i].d, int'(VEC[i].req));
                K_WT: wait_idle(int'(VEC[i].req));
                K_UL: pulse_unlock();
                default: ;
            endcase
        end

        // R10: address at strobe start, data at strobe end
        bus_write(10'h0A0, 8'h10);
        @(negedge clk);
        addr = 10'h0A0; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = 10'h0B0; din = 8'h0F;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; din = 8'h00;
        repeat (3) @(negedge clk);
        wait_idle(10);
        bus_read(10'h0A0, 8'h0F, 10);
        bus_read(10'h0B0, 8'hFF, 10);

        // R8: busy timing and length for a program (T_PROG = 16)
        bus_write(10'h0C0, 8'h10);
        bus_write(10'h0C0, 8'h00);
        check(busy === 1'b1, 8, int'(busy), 1, "busy after execute");
        bcnt = 0;
        while (busy === 1'b1 && bcnt < 100) begin
            @(negedge clk);
            bcnt++;
        end
        check(bcnt >= 14 && bcnt <= 16, 8, bcnt, 15, "program busy cycles");
        bus_read(10'h0C0, 8'h00, 3);

        // R9 / R11: partial sector erase, ignored write while busy, reissue
        bus_write(10'h100, 8'h10);
        bus_write(10'h100, 8'h00);
        wait_idle(9);
        bus_write(10'h1F0, 8'h10);
        bus_write(10'h1F0, 8'h00);
        wait_idle(9);
        bus_write(10'h100, 8'h20);
        bus_write(10'h100, 8'hD0);
        check(busy === 1'b1, 8, int'(busy), 1, "busy during sector erase");
        repeat (8) @(negedge clk);
        bus_write(10'h1F0, 8'h10);   // R11 ignored while running
        bus_write(10'h1F0, 8'hFF);   // R9 abort
        check(busy === 1'b0, 9, int'(busy), 0, "busy after abort");
        bus_read(10'h100, 8'hFF, 9);
        bus_read(10'h1F0, 8'h00, 9);
        bus_write(10'h1F0, 8'h00);   // R11 plain byte after abort: ignored
        wait_idle(11);
        bus_read(10'h1F0, 8'h00, 11);
        bus_write(10'h100, 8'h20);
        bus_write(10'h100, 8'hD0);
        wait_idle(9);
        bus_read(10'h1F0, 8'hFF, 9);
        bus_read(10'h0C0, 8'h00, 4);

        // R2: reset brings protection back
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_write(10'h010, 8'h10);
        bus_write(10'h010, 8'h00);
        check(busy === 1'b0, 2, int'(busy), 0, "no operation when protected");
        bus_read(10'h010, 8'hFF, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end
endmodule